// File: doc/BRIEF.md
# Safe Main Clock Controller

This block turns a main oscillator clock into the CPU clock and keeps the CPU clocked when that oscillator dies. In run mode the CPU clock is the source clock divided by two. In slow mode it is divided by 4, 8, 16 or 32. In active-halt the CPU clock is held low while a long wake-up timer, running from the always-present safe clock, counts toward a periodic wake event. In halt the CPU clock stops first, and then the oscillator enable output drops. An external wake input returns the block from either stop mode to run.

A monitor counts safe-clock cycles in which no main-clock activity is seen. When that count reaches a programmable limit, the controller moves the divider's source from the main clock to the safe clock through a two-flop enable on each source. It then raises a sticky status flag, which can drive the interrupt output. Only a reset moves the source back to the main clock. The watchdog clock output is the safe clock and runs in every mode.

Software uses two 8-bit registers, both clocked by the safe clock. The control register (address 0) holds the mode, the slow ratio, the wake period and two interrupt enables. The status register (address 1) holds two flags that are cleared by writing 1, a read-only source indicator and the loss limit.

Top module: `mcc_safe_clock_ctrl`

## Requirements
- R1: After reset the control register (address 0) reads 0x00, the status register (address 1) reads 0x80, irq is 0, osc_run is 1, and the CPU clock runs at half the main clock.
- R2: In run mode (control bits 1:0 = 0) the CPU clock period is two source-clock periods.
- R3: In slow mode (control bits 1:0 = 1) the CPU clock period is (4 << control bits 3:2) source periods. A new ratio takes effect only at the end of a complete CPU clock period.
- R4: In active-halt (control bits 1:0 = 2) the CPU clock stays low. After WAKE_BASE << (control bits 5:4) safe-clock cycles, the wake flag (status bit 1) is set and the mode returns to run.
- R5: In halt (control bits 1:0 = 3) the CPU clock stops and then osc_run goes low. A pulse on ext_wake returns the mode to run, raises osc_run and restarts the CPU clock from the main clock.
- R6: Outside halt, a run of safe-clock cycles with no main-clock activity that reaches the loss limit (status bits 7:4; values below 2 act as 2) sets the security flag (status bit 0) and the on-safe bit (status bit 2).
- R7: After a failure the CPU clock is derived from the safe clock with the same ratios. The two source enables are never active together.
- R8: The on-safe state and the source choice stay in place when the main clock resumes. Only reset returns the source to the main clock.
- R9: Writing 1 to status bit 0 or bit 1 clears that flag. Writing 0 to them has no effect, and status bit 2 is read-only.
- R10: irq is high exactly when the security flag is set with control bit 6 set, or when the wake flag is set with control bit 7 set.
- R11: wdg_clk keeps toggling in every mode, including halt.
- R12: The loss of the main clock during halt does not set the security flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Main oscillator clock |
| safe_clk | input | 1 | Low-frequency safe clock; also drives the registers |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, sampled on safe_clk |
| reg_addr | input | 1 | Register select: 0 control, 1 status |
| reg_wdata | input | 8 | Write data |
| ext_wake | input | 1 | External wake request for active-halt and halt |
| reg_rdata | output | 8 | Read data for the selected register |
| cpu_clk | output | 1 | Divided CPU clock |
| wdg_clk | output | 1 | Watchdog clock, always running |
| osc_run | output | 1 | Main oscillator enable |
| irq | output | 1 | Maskable interrupt request |

## Verification
The assertions assume that safe_clk always runs and that osc_clk runs whenever osc_run is high, except while a failure is being modelled. They also assume that reset is held for several cycles of both clocks, so the flops on each clock edge are cleared. The bench holds reset for six safe cycles with the oscillator enabled, and it drives all register and wake inputs half a safe cycle away from the sampling edge. After every ratio change it waits long enough for the synchronizers and the current CPU period to finish before it measures an edge-to-edge period.

// File: rtl/mcc_pkg.sv
// Shared types for the safe main clock controller.
// Assumes: the control register layout below is the software-visible one.
package mcc_pkg;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_SLOW  = 2'd1,
        MODE_AHALT = 2'd2,
        MODE_HALT  = 2'd3
    } mcc_mode_e;

    // Control register: bit 7 wake irq enable, bit 6 security irq enable,
    // bits 5:4 wake period select, bits 3:2 slow ratio select, bits 1:0 mode.
    typedef struct packed {
        logic      wake_ie;
        logic      css_ie;
        logic [1:0] wake_sel;
        logic [1:0] slow_sel;
        mcc_mode_e mode;
    } mcc_ctrl_t;

    // log2 of the division ratio requested by a mode and slow select
    function automatic logic [2:0] div_shift(mcc_mode_e m, logic [1:0] sel);
        return (m == MODE_SLOW) ? (3'(sel) + 3'd2) : 3'd1;
    endfunction

endpackage

// File: rtl/mcc_sync.sv
// Multi-stage synchronizer with a synchronous reset value.
// Assumes: multi-bit use only for quasi-static values that settle before use.
module mcc_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // capture the asynchronous input
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[i] <= RST_VAL;
                else        stage_q[i] <= d;
            end
        end else begin : g_next
            // shift toward the output
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[i] <= RST_VAL;
                else        stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/mcc_osc_monitor.sv
// Main clock loss detector. A toggle flop on the main clock is synchronized
// into the safe domain; a counter measures safe cycles without a toggle.
// Assumes: safe_clk always runs; lim is static while the main clock runs.
module mcc_osc_monitor #(
    parameter int LIM_W = 4
) (
    input  logic             osc_clk,
    input  logic             safe_clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [LIM_W-1:0] lim,
    output logic             fail
);
    localparam logic [LIM_W-1:0] MIN_LIM = LIM_W'(2);

    logic             tog_q;
    logic             tog_s;
    logic             tog_d;
    logic             edge_seen;
    logic [LIM_W-1:0] eff_lim;
    logic [LIM_W-1:0] idle_cnt;

    // activity marker in the main domain
    always_ff @(posedge osc_clk) begin
        if (!rst_n) tog_q <= 1'b0;
        else        tog_q <= ~tog_q;
    end

    mcc_sync #(.W(1), .STAGES(2), .RST_VAL(1'b0)) tog_sync_i (
        .clk   (safe_clk),
        .rst_n (rst_n),
        .d     (tog_q),
        .q     (tog_s)
    );

    // delayed copy for change detection
    always_ff @(posedge safe_clk) begin
        if (!rst_n) tog_d <= 1'b0;
        else        tog_d <= tog_s;
    end

    assign edge_seen = tog_s ^ tog_d;
    assign eff_lim   = (lim < MIN_LIM) ? MIN_LIM : lim;

    // idle counter and sticky failure decision
    always_ff @(posedge safe_clk) begin
        if (!rst_n) begin
            idle_cnt <= '0;
            fail     <= 1'b0;
        end else begin
            if (hold || edge_seen)      idle_cnt <= '0;
            else if (idle_cnt != eff_lim) idle_cnt <= idle_cnt + 1'b1;
            if (!hold && !edge_seen && idle_cnt == eff_lim) fail <= 1'b1;
        end
    end

    assert_fail_sticky_R8: assert property (@(posedge safe_clk) disable iff (!rst_n)
        fail |=> fail);
    assert_hold_no_fail_R12: assert property (@(posedge safe_clk) disable iff (!rst_n)
        (hold && !fail) |=> !fail);
endmodule

// File: rtl/mcc_clk_switch.sv
// One-way glitch-free source selector. Each source has a two-flop enable on
// its own falling edge, each arm waiting for the other to be released.
// The main path is also cut at once by use_safe, since its clock may be dead.
// Assumes: use_safe comes from the safe domain and never falls without reset.
module mcc_clk_switch (
    input  logic osc_clk,
    input  logic safe_clk,
    input  logic rst_n,
    input  logic use_safe,
    output logic src_clk,
    output logic on_safe
);
    logic [1:0] main_q;
    logic [1:0] safe_q;
    logic       main_live;

    assign main_live = main_q[1] & ~use_safe;

    // main enable arm, starts enabled so the divider sees clocks in reset
    always_ff @(negedge osc_clk) begin
        if (!rst_n) main_q <= 2'b11;
        else        main_q <= {main_q[0], ~use_safe & ~safe_q[1]};
    end

    // safe enable arm, waits for the main path to be released
    always_ff @(negedge safe_clk) begin
        if (!rst_n) safe_q <= 2'b00;
        else        safe_q <= {safe_q[0], use_safe & ~main_live};
    end

    assign src_clk = (osc_clk & main_live) | (safe_clk & safe_q[1]);
    assign on_safe = safe_q[1];

    assert_one_source_R7: assert property (@(posedge safe_clk) disable iff (!rst_n)
        !(main_live && safe_q[1]));
    assert_safe_sticky_R8: assert property (@(posedge safe_clk) disable iff (!rst_n)
        safe_q[1] |=> safe_q[1]);
endmodule

// File: rtl/mcc_divider.sv
// Power-of-two CPU clock divider on the selected source clock. The ratio and
// the stop request are loaded only at the end of a full output period, so
// the output never carries a short pulse. Stopped output rests low.
// Assumes: shift_req is in 1..MAX_SHIFT and changes rarely.
module mcc_divider #(
    parameter int MAX_SHIFT = 5
) (
    input  logic       src_clk,
    input  logic       rst_n,
    input  logic [2:0] shift_req,
    input  logic       stop_req,
    output logic       cpu_clk,
    output logic       stopped
);
    localparam logic [MAX_SHIFT-1:0] ONE = MAX_SHIFT'(1);

    logic [2:0]           shift_s;
    logic                 stop_s;
    logic [2:0]           k_cur;
    logic                 halted;
    logic                 clk_q;
    logic [MAX_SHIFT-1:0] cnt;
    logic [MAX_SHIFT-1:0] nxt;
    logic [MAX_SHIFT-1:0] mask;
    logic                 at_end;

    mcc_sync #(.W(4), .STAGES(2), .RST_VAL(4'b0001)) req_sync_i (
        .clk   (src_clk),
        .rst_n (rst_n),
        .d     ({stop_req, shift_req}),
        .q     ({stop_s, shift_s})
    );

    assign nxt    = cnt + ONE;
    assign mask   = (ONE << k_cur) - ONE;
    assign at_end = halted || (cnt == mask);

    // period counter, output phase and boundary loading
    always_ff @(posedge src_clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            k_cur  <= 3'd1;
            halted <= 1'b0;
            clk_q  <= 1'b0;
        end else if (at_end) begin
            cnt    <= '0;
            clk_q  <= 1'b0;
            k_cur  <= shift_s;
            halted <= stop_s;
        end else begin
            cnt    <= nxt;
            clk_q  <= nxt[k_cur - 3'd1];
        end
    end

    assign cpu_clk = clk_q;
    assign stopped = halted;

    assert_ratio_at_boundary_R3: assert property (@(posedge src_clk) disable iff (!rst_n)
        !at_end |=> $stable(k_cur));
    assert_halt_low_R4: assert property (@(posedge src_clk) disable iff (!rst_n)
        halted |-> !clk_q);
endmodule

// File: rtl/mcc_safe_clock_ctrl.sv
// Top of the safe main clock controller: register file, wake-up timer and
// mode sequencing in the safe domain, with monitor, switch and divider below.
// Assumes: register accesses are synchronous to safe_clk.
module mcc_safe_clock_ctrl
    import mcc_pkg::*;
#(
    parameter int WAKE_BASE = 32000,
    parameter int LIM_W     = 4,
    parameter int LOSS_INIT = 8
) (
    input  logic       osc_clk,
    input  logic       safe_clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic       reg_addr,
    input  logic [7:0] reg_wdata,
    input  logic       ext_wake,
    output logic [7:0] reg_rdata,
    output logic       cpu_clk,
    output logic       wdg_clk,
    output logic       osc_run,
    output logic       irq
);
    localparam int WAKE_W = $clog2(WAKE_BASE * 8 + 1);

    mcc_ctrl_t        ctrl_q;
    logic             css_flag;
    logic             wake_flag;
    logic [LIM_W-1:0] lim_q;
    logic [WAKE_W-1:0] wcnt;
    logic [WAKE_W-1:0] wake_len;
    logic             wake_hit;
    logic             fail;
    logic             fail_d;
    logic             on_safe;
    logic             src_clk;
    logic             div_stopped;
    logic             stopped_s;
    logic             wr_ctrl;
    logic             wr_stat;

    assign wr_ctrl  = reg_wr && !reg_addr;
    assign wr_stat  = reg_wr && reg_addr;
    assign wake_len = WAKE_W'(WAKE_BASE) << ctrl_q.wake_sel;
    assign wake_hit = (ctrl_q.mode == MODE_AHALT) && (wcnt == wake_len - 1'b1);

    // registers, flags, wake timer and mode exits
    always_ff @(posedge safe_clk) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            css_flag  <= 1'b0;
            wake_flag <= 1'b0;
            lim_q     <= LIM_W'(LOSS_INIT);
            wcnt      <= '0;
            fail_d    <= 1'b0;
        end else begin
            fail_d <= fail;
            wcnt   <= (ctrl_q.mode == MODE_AHALT && !wake_hit) ? wcnt + 1'b1 : '0;
            if (fail && !fail_d)            css_flag <= 1'b1;
            else if (wr_stat && reg_wdata[0]) css_flag <= 1'b0;
            if (wake_hit)                   wake_flag <= 1'b1;
            else if (wr_stat && reg_wdata[1]) wake_flag <= 1'b0;
            if (wr_stat) lim_q <= reg_wdata[7:4];
            if (wr_ctrl)
                ctrl_q <= mcc_ctrl_t'(reg_wdata);
            else if (wake_hit || (ext_wake && ctrl_q.mode[1]))
                ctrl_q.mode <= MODE_RUN;
        end
    end

    mcc_sync #(.W(1), .STAGES(2), .RST_VAL(1'b0)) stop_sync_i (
        .clk   (safe_clk),
        .rst_n (rst_n),
        .d     (div_stopped),
        .q     (stopped_s)
    );

    assign osc_run = !((ctrl_q.mode == MODE_HALT) && stopped_s);

    mcc_osc_monitor #(.LIM_W(LIM_W)) monitor_i (
        .osc_clk  (osc_clk),
        .safe_clk (safe_clk),
        .rst_n    (rst_n),
        .hold     (ctrl_q.mode == MODE_HALT),
        .lim      (lim_q),
        .fail     (fail)
    );

    mcc_clk_switch switch_i (
        .osc_clk  (osc_clk),
        .safe_clk (safe_clk),
        .rst_n    (rst_n),
        .use_safe (fail),
        .src_clk  (src_clk),
        .on_safe  (on_safe)
    );

    mcc_divider #(.MAX_SHIFT(5)) divider_i (
        .src_clk   (src_clk),
        .rst_n     (rst_n),
        .shift_req (div_shift(ctrl_q.mode, ctrl_q.slow_sel)),
        .stop_req  (ctrl_q.mode[1]),
        .cpu_clk   (cpu_clk),
        .stopped   (div_stopped)
    );

    assign reg_rdata = reg_addr ? {4'(lim_q), 1'b0, on_safe, wake_flag, css_flag}
                                : ctrl_q;
    assign irq       = (css_flag & ctrl_q.css_ie) | (wake_flag & ctrl_q.wake_ie);
    assign wdg_clk   = safe_clk;

    assert_css_follows_fail_R6: assert property (@(posedge safe_clk) disable iff (!rst_n)
        $rose(fail) |=> css_flag);
    assert_wake_from_ahalt_R4: assert property (@(posedge safe_clk) disable iff (!rst_n)
        $rose(wake_flag) |-> ($past(ctrl_q.mode) == MODE_AHALT));
    assert_wake_exits_R4: assert property (@(posedge safe_clk) disable iff (!rst_n)
        ($rose(wake_flag) && !$past(wr_ctrl)) |-> (ctrl_q.mode == MODE_RUN));
endmodule

// File: tb/mcc_safe_clock_ctrl_tb.sv
module mcc_safe_clock_ctrl_tb_top;
    localparam int CLK_PERIOD  = 10;
    localparam int SAFE_PERIOD = 46;

    logic       osc_clk  = 1'b0;
    logic       safe_clk = 1'b0;
    logic       rst_n    = 1'b0;
    logic       reg_wr   = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic       ext_wake = 1'b0;
    logic       osc_kill = 1'b0;
    logic [7:0] reg_rdata;
    logic       cpu_clk, wdg_clk, osc_run, irq;

    int tests = 0;
    int fails = 0;

    // {control value, expected CPU period in ns on the main clock}
    localparam logic [23:0] VEC [6] = '{
        {8'h00, 16'd20}, {8'h01, 16'd40}, {8'h05, 16'd80},
        {8'h09, 16'd160}, {8'h0D, 16'd320}, {8'h00, 16'd20}
    };

    mcc_safe_clock_ctrl #(.WAKE_BASE(20)) dut_i (
        .osc_clk(osc_clk), .safe_clk(safe_clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .ext_wake(ext_wake), .reg_rdata(reg_rdata), .cpu_clk(cpu_clk),
        .wdg_clk(wdg_clk), .osc_run(osc_run), .irq(irq)
    );

    always #(CLK_PERIOD/2) osc_clk = (osc_run === 1'b1 && !osc_kill) ? ~osc_clk : 1'b0;
    always #(SAFE_PERIOD/2) safe_clk = ~safe_clk;

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic safe_wait(input int n);
        for (int i = 0; i < n; i++) @(negedge safe_clk);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge safe_clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge safe_clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output int v);
        @(negedge safe_clk);
        reg_addr = a;
        #2;
        v = int'(reg_rdata);
    endtask

    // count rising edges of a clock over a window, report the last gap
    task automatic edges(input bit use_wdg, input int dur, output int n, output int gap);
        logic prev;
        int   last_t;
        n = 0; gap = 0; last_t = 0;
        prev = use_wdg ? wdg_clk : cpu_clk;
        for (int t = 0; t < dur; t++) begin
            logic cur;
            #1;
            cur = use_wdg ? wdg_clk : cpu_clk;
            if (cur && !prev) begin
                if (n > 0) gap = int'($time) - last_t;
                last_t = int'($time);
                n++;
            end
            prev = cur;
        end
    endtask

    task automatic do_reset();
        osc_kill = 1'b0;
        @(negedge safe_clk);
        rst_n = 1'b0;
        safe_wait(6);
        #2;
        rst_n = 1'b1;
        safe_wait(4);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int v, n, gap;
        do_reset();

        // R1 reset state
        rd(1'b0, v); chk("R1 ctrl", v, 8'h00);
        rd(1'b1, v); chk("R1 status", v, 8'h80);
        chk("R1 irq", int'(irq), 0);
        chk("R1 osc_run", int'(osc_run), 1);
        edges(1'b0, 100, n, gap); chk("R1 period", gap, 20);

        // R2 R3 ratio table
        for (int i = 0; i < 6; i++) begin
            wr(1'b0, VEC[i][23:16]);
            safe_wait(10);
            edges(1'b0, 3 * int'(VEC[i][15:0]) + 5, n, gap);
            chk(i == 0 || i == 5 ? "R2 run period" : "R3 slow period", gap, int'(VEC[i][15:0]));
        end

        // R4 active-halt, 20 cycles, wake irq enabled
        wr(1'b0, 8'h82);
        safe_wait(4);
        edges(1'b0, 6 * SAFE_PERIOD, n, gap); chk("R4 cpu held", n, 0);
        safe_wait(20);
        rd(1'b1, v); chk("R4 wake flag set", v, 8'h82);
        rd(1'b0, v); chk("R4 back to run", v, 8'h80);
        chk("R10 wake irq", int'(irq), 1);
        edges(1'b0, 100, n, gap); chk("R4 resumed period", gap, 20);
        wr(1'b1, 8'h82);
        rd(1'b1, v); chk("R9 wake cleared", v, 8'h80);
        chk("R10 irq low", int'(irq), 0);

        // R4 longer period, irq disabled
        wr(1'b0, 8'h12);
        safe_wait(30);
        rd(1'b1, v); chk("R4 not yet at 30", v, 8'h80);
        safe_wait(20);
        rd(1'b1, v); chk("R4 flag at 50", v, 8'h82);
        chk("R10 masked", int'(irq), 0);
        wr(1'b1, 8'h80);
        rd(1'b1, v); chk("R9 write 0 ignored", v, 8'h82);
        wr(1'b1, 8'h82);

        // R5 R11 R12 halt
        wr(1'b0, 8'h03);
        safe_wait(10);
        chk("R5 osc off", int'(osc_run), 0);
        edges(1'b0, 8 * SAFE_PERIOD, n, gap); chk("R5 cpu stopped", n, 0);
        edges(1'b1, 8 * SAFE_PERIOD, n, gap); chk("R11 wdg period", gap, SAFE_PERIOD);
        safe_wait(12);
        rd(1'b1, v); chk("R12 no flag in halt", v, 8'h80);
        @(negedge safe_clk); ext_wake = 1'b1;
        @(negedge safe_clk); ext_wake = 1'b0;
        rd(1'b0, v); chk("R5 mode run", v, 8'h00);
        chk("R5 osc on", int'(osc_run), 1);
        safe_wait(4);
        edges(1'b0, 100, n, gap); chk("R5 main restart", gap, 20);

        // R6 R7 R8 R9 R10 failure
        @(negedge safe_clk); osc_kill = 1'b1;
        safe_wait(5);
        rd(1'b1, v); chk("R6 not early", v & 1, 0);
        safe_wait(15);
        rd(1'b1, v); chk("R6 flag and on_safe", v, 8'h85);
        chk("R10 masked css", int'(irq), 0);
        wr(1'b0, 8'h40);
        chk("R10 css irq", int'(irq), 1);
        safe_wait(4);
        edges(1'b0, 4 * 2 * SAFE_PERIOD, n, gap); chk("R7 safe run period", gap, 2 * SAFE_PERIOD);
        wr(1'b0, 8'h45);
        safe_wait(12);
        edges(1'b0, 3 * 8 * SAFE_PERIOD, n, gap); chk("R7 safe slow period", gap, 8 * SAFE_PERIOD);
        osc_kill = 1'b0;
        safe_wait(20);
        rd(1'b1, v); chk("R8 stays on safe", v & 4, 4);
        edges(1'b0, 3 * 8 * SAFE_PERIOD, n, gap); chk("R8 still safe clock", gap, 8 * SAFE_PERIOD);
        wr(1'b1, 8'h85);
        rd(1'b1, v); chk("R9 on_safe read-only", v, 8'h84);
        chk("R10 irq cleared", int'(irq), 0);
        do_reset();
        rd(1'b1, v); chk("R8 reset returns", v, 8'h80);
        edges(1'b0, 100, n, gap); chk("R8 main after reset", gap, 20);

        // R6 limit below 2 acts as 2
        wr(1'b1, 8'h10);
        @(negedge safe_clk); osc_kill = 1'b1;
        safe_wait(10);
        rd(1'b1, v); chk("R6 low limit", v, 8'h15);
        do_reset();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule